// File: doc/BRIEF.md
# Packed Low-Half SIMD Multiplier

This unit multiplies two packed vectors lane by lane on a 256-bit datapath. A lane-size select picks signed 16-bit (narrow) or signed 32-bit (wide) lanes. Each lane pair yields a full-width signed product, and only its low half is written back into the matching result lane. Bits above the kept half are dropped without any flag or exception. Because only the low half is kept, the result bits are the same whether the operands are read as signed or unsigned.

A 2-bit variant select chooses the writeback policy for the upper 128 result bits. In the destructive 128-bit form, the prior destination value is the first multiplicand and its upper half passes through unchanged. The non-destructive 128-bit form multiplies two independent sources and clears the upper half. The full-width form computes every lane across all 256 bits. A valid strobe travels with the data, and a parameter sets the latency to zero cycles (purely combinational) or one cycle (one register stage).

Top module: `simd_mullo`

## Requirements
- R1: With `lane_dw`=0 each 16-bit lane k (bits 16k+15..16k) of the result equals bits [15:0] of the signed product of the two 16-bit operand lanes k.
- R2: With `lane_dw`=1 each 32-bit lane k (bits 32k+31..32k) of the result equals bits [31:0] of the signed product of the two 32-bit operand lanes k.
- R3: A result lane depends only on the operand lanes at the same bit position. A non-zero pair in one lane leaves every other lane at zero.
- R4: With `variant`=2'b10 all 16 narrow or 8 wide lanes of `src_a`×`src_b` are computed across result bits [255:0].
- R5: With `variant`=2'b01 result bits [127:0] hold the lanes of `src_a`×`src_b` and bits [255:128] are zero.
- R6: With `variant`=2'b00 the first multiplicand is `dst_prev`, the second is `src_b`, bits [127:0] hold the products, bits [255:128] equal `dst_prev[255:128]`, and `src_a` has no effect.
- R7: `out_valid` equals `in_valid` delayed by LATENCY cycles (0 or 1), and `result` belongs to the operation flagged by `out_valid` in the same cycle.
- R8: With `variant`=2'b11 the result is all zero and `out_valid` still follows `in_valid`.
- R9: Overflow beyond the kept half is discarded silently. For example, 0x8000×0x8000 gives 0x0000, 0xFFFF×0xFFFF gives 0x0001, and 0x80000000×0x80000000 gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| lane_dw | input | 1 | Lane size: 0 = 16-bit, 1 = 32-bit |
| variant | input | 2 | Writeback policy: 00 keep upper, 01 zero upper, 10 full width, 11 reserved |
| src_a | input | DATA_W | First source vector (non-destructive forms) |
| src_b | input | DATA_W | Second source vector |
| dst_prev | input | DATA_W | Prior destination value |
| out_valid | output | 1 | Result valid |
| result | output | DATA_W | Packed low-half products |

## Verification
The bench takes LATENCY as its own parameter and passes it to the unit. Its default of 1 exercises the register stage, valid-bubble cycles and the capture of operands only on valid cycles. With LATENCY set to 0 the same sequences check the combinational path, with every result compared in the cycle it is driven. The default DATA_W=256 and NARROW_W=16 make the extreme-operand, single-lane-isolation and upper-half policy cases reachable across all three variants.

// File: rtl/simd_mullo_pkg.sv
package simd_mullo_pkg;

   typedef enum logic [1:0] {
      WB_KEEP_UPPER = 2'b00,
      WB_ZERO_UPPER = 2'b01,
      WB_FULL       = 2'b10,
      WB_RESERVED   = 2'b11
   } wb_mode_e;

endpackage

// File: rtl/mullo_lane.sv
module mullo_lane #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] prod_lo
);
   // Low W bits of a W x W product depend only on the low W bits of the
   // operands, so the product is formed at width W directly.
   assign prod_lo = W'($signed(op_a) * $signed(op_b));
endmodule

// File: rtl/mullo_array.sv
module mullo_array #(
   parameter int unsigned DATA_W   = 256,
   parameter int unsigned NARROW_W = 16
) (
   input  logic              lane_dw,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] prod
);
   localparam int unsigned WIDE_W = 2 * NARROW_W;
   localparam int unsigned N_WIDE = DATA_W / WIDE_W;

   for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
      logic [WIDE_W-1:0]   wide_p;
      logic [NARROW_W-1:0] lo_p;
      logic [NARROW_W-1:0] hi_p;

      mullo_lane #(.W(WIDE_W)) i_wide (
         .op_a   (op_a[g*WIDE_W +: WIDE_W]),
         .op_b   (op_b[g*WIDE_W +: WIDE_W]),
         .prod_lo(wide_p)
      );
      mullo_lane #(.W(NARROW_W)) i_lo (
         .op_a   (op_a[g*WIDE_W +: NARROW_W]),
         .op_b   (op_b[g*WIDE_W +: NARROW_W]),
         .prod_lo(lo_p)
      );
      mullo_lane #(.W(NARROW_W)) i_hi (
         .op_a   (op_a[g*WIDE_W+NARROW_W +: NARROW_W]),
         .op_b   (op_b[g*WIDE_W+NARROW_W +: NARROW_W]),
         .prod_lo(hi_p)
      );

      assign prod[g*WIDE_W +: WIDE_W] = lane_dw ? wide_p : {hi_p, lo_p};
   end
endmodule

// File: rtl/mullo_wb.sv
module mullo_wb
   import simd_mullo_pkg::*;
#(
   parameter int unsigned DATA_W = 256
) (
   input  wb_mode_e          mode,
   input  logic [DATA_W-1:0] prod,
   input  logic [DATA_W-1:0] dst_prev,
   output logic [DATA_W-1:0] res
);
   localparam int unsigned HALF_W = DATA_W / 2;

   always_comb begin
      unique case (mode)
         WB_KEEP_UPPER: res = {dst_prev[DATA_W-1:HALF_W], prod[HALF_W-1:0]};
         WB_ZERO_UPPER: res = {{HALF_W{1'b0}}, prod[HALF_W-1:0]};
         WB_FULL:       res = prod;
         default:       res = '0;
      endcase
   end
endmodule

// File: rtl/simd_mullo.sv
module simd_mullo
   import simd_mullo_pkg::*;
#(
   parameter int unsigned DATA_W   = 256,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned LATENCY  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              lane_dw,
   input  logic [1:0]        variant,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] dst_prev,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   localparam int unsigned WIDE_W = 2 * NARROW_W;

   if (DATA_W % (2 * WIDE_W) != 0) begin : g_bad_width
      $error("simd_mullo: DATA_W must hold a whole number of wide lanes per half");
   end
   if (LATENCY > 1) begin : g_bad_latency
      $error("simd_mullo: LATENCY must be 0 or 1");
   end

   wb_mode_e          mode;
   logic [DATA_W-1:0] first_op;
   logic [DATA_W-1:0] prod;
   logic [DATA_W-1:0] res_c;

   assign mode     = wb_mode_e'(variant);
   // Destructive form reads its first multiplicand from the destination.
   assign first_op = (mode == WB_KEEP_UPPER) ? dst_prev : src_a;

   mullo_array #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_array (
      .lane_dw(lane_dw),
      .op_a   (first_op),
      .op_b   (src_b),
      .prod   (prod)
   );

   mullo_wb #(.DATA_W(DATA_W)) i_wb (
      .mode    (mode),
      .prod    (prod),
      .dst_prev(dst_prev),
      .res     (res_c)
   );

   if (LATENCY == 0) begin : g_comb
      assign out_valid = in_valid;
      assign result    = res_c;
   end else begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= res_c;
         end
      end
      assign out_valid = vld_q;
      assign result    = res_q;
   end
endmodule

// File: rtl/simd_mullo_chk.sv
module simd_mullo_chk #(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned LATENCY = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        variant,
   input logic [DATA_W-1:0] dst_prev,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   localparam int unsigned HALF_W = DATA_W / 2;

   logic              d_valid;
   logic [1:0]        d_variant;
   logic [HALF_W-1:0] d_prev_hi;

   if (LATENCY == 0) begin : g_now
      assign d_valid   = in_valid;
      assign d_variant = variant;
      assign d_prev_hi = dst_prev[DATA_W-1:HALF_W];
   end else begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_valid   <= 1'b0;
            d_variant <= 2'b00;
            d_prev_hi <= '0;
         end else begin
            d_valid <= in_valid;
            if (in_valid) begin
               d_variant <= variant;
               d_prev_hi <= dst_prev[DATA_W-1:HALF_W];
            end
         end
      end
   end

   assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == d_valid);

   assert_zero_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && d_variant == 2'b01) |-> (result[DATA_W-1:HALF_W] == '0));

   assert_keep_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && d_variant == 2'b00) |-> (result[DATA_W-1:HALF_W] == d_prev_hi));

   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && d_variant == 2'b11) |-> (result == '0));
endmodule

bind simd_mullo simd_mullo_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .variant  (variant),
   .dst_prev (dst_prev),
   .out_valid(out_valid),
   .result   (result)
);

// File: tb/test_simd_mullo.sv
module test_simd_mullo #(
   parameter int unsigned LATENCY = 1
);
   localparam int unsigned CLK_P = 10;
   localparam int unsigned DW    = 256;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic          lane_dw;
   logic [1:0]    variant;
   logic [DW-1:0] src_a, src_b, dst_prev;
   logic          out_valid;
   logic [DW-1:0] result;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_P/2) clk = ~clk;

   simd_mullo #(.DATA_W(DW), .NARROW_W(16), .LATENCY(LATENCY)) i_simd_mullo (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_dw(lane_dw),
      .variant(variant), .src_a(src_a), .src_b(src_b), .dst_prev(dst_prev),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [DW-1:0] model(input logic dw, input logic [1:0] vr,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic [DW-1:0] p);
      logic [DW-1:0] r;
      logic [DW-1:0] x;
      int            nbits;
      r = '0;
      if (vr == 2'b11) return r;
      x     = (vr == 2'b00) ? p : a;
      nbits = (vr == 2'b10) ? 256 : 128;
      if (!dw) begin
         for (int i = 0; i < nbits / 16; i++) begin
            longint prd;
            prd = longint'($signed(x[i*16 +: 16])) * longint'($signed(b[i*16 +: 16]));
            r[i*16 +: 16] = prd[15:0];
         end
      end else begin
         for (int i = 0; i < nbits / 32; i++) begin
            longint prd;
            prd = longint'($signed(x[i*32 +: 32])) * longint'($signed(b[i*32 +: 32]));
            r[i*32 +: 32] = prd[31:0];
         end
      end
      if (vr == 2'b00) r[255:128] = p[255:128];
      return r;
   endfunction

   function automatic logic [DW-1:0] rnd256();
      logic [DW-1:0] r;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
      return r;
   endfunction

   task automatic check(input string req, input logic exp_v, input logic [DW-1:0] exp_r);
      n_checks++;
      if (out_valid !== exp_v || (exp_v && result !== exp_r)) begin
         n_fail++;
         $display("FAIL %s: valid=%b result=%h expected valid=%b result=%h",
                  req, out_valid, result, exp_v, exp_r);
      end
   endtask

   // Drive one operation at the falling edge, compare after the next rising edge.
   task automatic step(input string req, input logic v, input logic dw, input logic [1:0] vr,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] p);
      @(negedge clk);
      in_valid = v; lane_dw = dw; variant = vr;
      src_a = a; src_b = b; dst_prev = p;
      @(posedge clk);
      #(CLK_P/4);
      check(req, v, model(dw, vr, a, b, p));
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] lane3;
      logic [DW-1:0] hold_r;
      rst_n = 1'b0; in_valid = 1'b0; lane_dw = 1'b0; variant = 2'b00;
      src_a = '0; src_b = '0; dst_prev = '0;
      repeat (3) @(negedge clk);
      // Reset state: no valid output (R7)
      check("R7 reset", 1'b0, '0);
      rst_n = 1'b1;

      // R1: narrow lanes, mixed signs, full width
      step("R1 narrow mixed", 1, 0, 2'b10, {16{16'hFFFD}}, {16{16'h0007}}, '0);
      step("R1 narrow ramp",  1, 0, 2'b10, {8{32'h1234_8001}}, {8{32'h0003_7FFF}}, '0);
      // R2: wide lanes
      step("R2 wide mixed", 1, 1, 2'b10, {8{32'hFFFF_FFFE}}, {8{32'h4000_0003}}, '0);
      step("R2 wide big",   1, 1, 2'b10, {8{32'h0001_2345}}, {8{32'h0006_789A}}, '0);
      // R9: extreme operands wrap silently
      step("R9 narrow 8000^2", 1, 0, 2'b10, {16{16'h8000}}, {16{16'h8000}}, '0);
      step("R9 narrow FFFF^2", 1, 0, 2'b10, {16{16'hFFFF}}, {16{16'hFFFF}}, '0);
      step("R9 wide 80000000^2", 1, 1, 2'b10, {8{32'h8000_0000}}, {8{32'h8000_0000}}, '0);
      // R3: single active lane, others must stay zero
      lane3 = '0; lane3[63:48] = 16'h7FFF;
      step("R3 narrow isolation", 1, 0, 2'b10, lane3, lane3, '0);
      lane3 = '0; lane3[223:192] = 32'h8765_4321;
      step("R3 wide isolation", 1, 1, 2'b10, lane3, lane3, '0);
      // R4: full width random
      step("R4 full narrow", 1, 0, 2'b10, rnd256(), rnd256(), rnd256());
      step("R4 full wide",   1, 1, 2'b10, rnd256(), rnd256(), rnd256());
      // R5: 128-bit non-destructive clears the upper half
      step("R5 zero upper narrow", 1, 0, 2'b01, rnd256(), rnd256(), {DW{1'b1}});
      step("R5 zero upper wide",   1, 1, 2'b01, rnd256(), rnd256(), {DW{1'b1}});
      // R6: destructive form, src_a must not matter
      step("R6 keep upper narrow", 1, 0, 2'b00, '0, {16{16'h0005}}, {16{16'h0101}});
      hold_r = result;
      step("R6 src_a ignored", 1, 0, 2'b00, {DW{1'b1}}, {16{16'h0005}}, {16{16'h0101}});
      n_checks++;
      if (result !== hold_r) begin
         n_fail++;
         $display("FAIL R6 src_a affected result: %h expected %h", result, hold_r);
      end
      step("R6 keep upper wide", 1, 1, 2'b00, rnd256(), rnd256(), rnd256());
      // R8: reserved code gives zero with valid
      step("R8 reserved narrow", 1, 0, 2'b11, rnd256(), rnd256(), rnd256());
      step("R8 reserved wide",   1, 1, 2'b11, {DW{1'b1}}, {DW{1'b1}}, {DW{1'b1}});
      // R7: bubbles give no valid; following op still correct
      step("R7 bubble", 0, 0, 2'b10, rnd256(), rnd256(), rnd256());
      step("R7 after bubble", 1, 1, 2'b10, rnd256(), rnd256(), rnd256());
      step("R7 bubble 2", 0, 1, 2'b01, rnd256(), rnd256(), rnd256());
      // Random mix over all modes
      for (int k = 0; k < 60; k++) begin
         step("R4 random mix", 1'($urandom), 1'($urandom), 2'($urandom),
              rnd256(), rnd256(), rnd256());
      end
      @(negedge clk);
      in_valid = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule